// File: doc/BRIEF.md
# Planar Color Expansion Write Unit

This datapath works out, for one processor write into four-plane video memory, the byte to store in each plane and the bit-enable mask that goes with it. It turns a monochrome source byte into colored plane data. It can also fall back to plain set/reset data, per-plane dither patterns, or a copy of the latched background.

The memory controller pulses a write strobe with the processor byte and the current register contents. One clock later the unit presents the four plane bytes and the write mask, together with a valid flag. Plane data for bits that may not be written already holds the read-latch value. A controller can therefore write either the whole word or only the enabled bits and get the same result.

Top module: `cexp_write_unit`

## Requirements
- R1: The monochrome source byte is `cpu_data` when `src_cpu` is 1, and `pattern` when `src_cpu` is 0. The source is used in mode 1.
- R2: In mode 0 (`mode`=2'b00), plane n receives eight copies of `sr_value[n]` when `sr_enable[n]` is 1, and `cpu_data` otherwise.
- R3: In mode 1 (`mode`=2'b01), bit b of plane n equals `fg_color[n]` when source bit b is 1, and `bg_color[n]` when it is 0.
- R4: In mode 2 (`mode`=2'b10), plane n receives the foreground latch byte `fg_latch[8n+7:8n]`.
- R5: In mode 3 (`mode`=2'b11), plane n receives the background latch byte `rd_latch[8n+7:8n]`.
- R6: `wr_mask` equals `bit_mask` ANDed with the masked-write mask. When `mw_enable` is 0, the masked-write mask is all ones. When `mw_enable` is 1, it is `cpu_data` if `mw_use_cpu` is 1, and `mw_mask` if `mw_use_cpu` is 0.
- R7: Every plane bit whose `wr_mask` bit is 0 carries the matching `rd_latch` bit.
- R8: Results and `out_valid`=1 appear on the first rising clock edge after `wr_stb` is sampled high. `out_valid` is 0 after a cycle with no strobe.
- R9: When no strobe is sampled, `plane_data` and `wr_mask` keep their values.
- R10: While `rst_n` is low, `plane_data`, `wr_mask` and `out_valid` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per processor write |
| cpu_data | input | 8 | Processor data byte |
| pattern | input | 8 | Pattern register byte |
| src_cpu | input | 1 | Selects the processor byte as the monochrome source |
| mode | input | 2 | Write mode: 0 set/reset, 1 solid expansion, 2 dither, 3 transparent |
| fg_color | input | 4 | Foreground color, one bit per plane |
| bg_color | input | 4 | Background color, one bit per plane |
| fg_latch | input | 32 | Four foreground latch bytes, plane n at bits 8n+7:8n |
| rd_latch | input | 32 | Four background/read latch bytes, plane n at bits 8n+7:8n |
| sr_value | input | 4 | Set/reset value, one bit per plane |
| sr_enable | input | 4 | Set/reset enable, one bit per plane |
| bit_mask | input | 8 | Standard bit mask |
| mw_enable | input | 1 | Enables the masked-write mask |
| mw_use_cpu | input | 1 | Takes the masked-write mask from the processor byte |
| mw_mask | input | 8 | Masked-write mask register |
| plane_data | output | 32 | Four plane bytes, plane n at bits 8n+7:8n |
| wr_mask | output | 8 | Per-bit write enable |
| out_valid | output | 1 | Results on the outputs belong to the last strobe |

## Verification
The hardest case to reach is the one where the processor byte does three jobs at once. It is the data, it is the expansion source, and it is the write mask. A fault in which of these paths the byte feeds hides unless the pattern register, the masked-write register and the processor byte all hold different values. The random stimulus draws every byte independently, so most writes satisfy that condition. Directed writes then force the processor-mask path in mode 1, once with the pattern source and once with the processor source. Hold behaviour is checked by changing every input during cycles with no strobe and confirming that the outputs keep their values.

// File: rtl/cexp_write_unit.sv
module cexp_write_unit #(
  parameter int PLANES = 4,
  parameter int BW = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_stb,
  input  logic [BW-1:0]        cpu_data,
  input  logic [BW-1:0]        pattern,
  input  logic                 src_cpu,
  input  logic [1:0]           mode,
  input  logic [PLANES-1:0]    fg_color,
  input  logic [PLANES-1:0]    bg_color,
  input  logic [PLANES*BW-1:0] fg_latch,
  input  logic [PLANES*BW-1:0] rd_latch,
  input  logic [PLANES-1:0]    sr_value,
  input  logic [PLANES-1:0]    sr_enable,
  input  logic [BW-1:0]        bit_mask,
  input  logic                 mw_enable,
  input  logic                 mw_use_cpu,
  input  logic [BW-1:0]        mw_mask,
  output logic [PLANES*BW-1:0] plane_data,
  output logic [BW-1:0]        wr_mask,
  output logic                 out_valid
);
  localparam int DW = PLANES * BW;

  logic [BW-1:0] src, en;
  logic [DW-1:0] nxt;

  assign src = src_cpu ? cpu_data : pattern;
  assign en  = bit_mask & (mw_enable ? (mw_use_cpu ? cpu_data : mw_mask) : {BW{1'b1}});

  for (genvar n = 0; n < PLANES; n++) begin : g_plane
    logic [BW-1:0] raw;
    always_comb begin
      unique case (mode)
        2'd0:    raw = sr_enable[n] ? {BW{sr_value[n]}} : cpu_data;
        2'd1:    raw = (src & {BW{fg_color[n]}}) | (~src & {BW{bg_color[n]}});
        2'd2:    raw = fg_latch[n*BW +: BW];
        default: raw = rd_latch[n*BW +: BW];
      endcase
    end
    assign nxt[n*BW +: BW] = (raw & en) | (rd_latch[n*BW +: BW] & ~en);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      plane_data <= '0;
      wr_mask    <= '0;
      out_valid  <= 1'b0;
    end else begin
      out_valid <= wr_stb;
      if (wr_stb) begin
        plane_data <= nxt;
        wr_mask    <= en;
      end
    end
  end
endmodule

// File: rtl/cexp_write_unit_chk.sv
module cexp_write_unit_chk #(
  parameter int PLANES = 4,
  parameter int BW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 wr_stb,
  input logic [1:0]           mode,
  input logic [PLANES*BW-1:0] rd_latch,
  input logic [BW-1:0]        bit_mask,
  input logic [PLANES*BW-1:0] plane_data,
  input logic [BW-1:0]        wr_mask,
  input logic                 out_valid
);
  p_valid_after_stb_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> out_valid);
  p_no_valid_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> !out_valid);
  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> ($stable(plane_data) && $stable(wr_mask)));
  p_mask_within_bitmask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> ((wr_mask & ~$past(bit_mask)) == '0));
  p_masked_bits_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> (((plane_data ^ $past(rd_latch)) & ~{PLANES{wr_mask}}) == '0));
  p_transparent_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && mode == 2'd3) |=> (plane_data == $past(rd_latch)));
  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_n |=> (plane_data == '0 && wr_mask == '0 && !out_valid));
endmodule

bind cexp_write_unit cexp_write_unit_chk #(.PLANES(PLANES), .BW(BW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .mode(mode), .rd_latch(rd_latch),
  .bit_mask(bit_mask), .plane_data(plane_data), .wr_mask(wr_mask), .out_valid(out_valid)
);

// File: tb/tb_cexp_write_unit.sv
`timescale 1ns/1ps
module tb_cexp_write_unit;
  logic clk = 0, rst_n = 0, wr_stb = 0;
  logic [7:0] cpu_data = 0, pattern = 0, bit_mask = 0, mw_mask = 0;
  logic src_cpu = 0, mw_enable = 0, mw_use_cpu = 0;
  logic [1:0] mode = 0;
  logic [3:0] fg_color = 0, bg_color = 0, sr_value = 0, sr_enable = 0;
  logic [31:0] fg_latch = 0, rd_latch = 0, plane_data;
  logic [7:0] wr_mask;
  logic out_valid;
  int total = 0, bad = 0;
  logic [31:0] exp_d, held_d;
  logic [7:0] exp_m, held_m;

  always #2.5 clk = ~clk;

  cexp_write_unit dut (.*);

  function automatic logic [7:0] f_mask();
    logic [7:0] m;
    m = mw_enable ? (mw_use_cpu ? cpu_data : mw_mask) : 8'hFF;
    return bit_mask & m;
  endfunction

  function automatic logic [31:0] f_data(input logic [7:0] en);
    logic [31:0] r;
    logic [7:0] s, raw;
    s = src_cpu ? cpu_data : pattern;
    for (int n = 0; n < 4; n++) begin
      for (int b = 0; b < 8; b++) begin
        case (mode)
          2'd0: raw[b] = sr_enable[n] ? sr_value[n] : cpu_data[b];
          2'd1: raw[b] = s[b] ? fg_color[n] : bg_color[n];
          2'd2: raw[b] = fg_latch[n*8+b];
          default: raw[b] = rd_latch[n*8+b];
        endcase
        r[n*8+b] = en[b] ? raw[b] : rd_latch[n*8+b];
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  task automatic randomize_inputs();
    cpu_data = 8'($urandom); pattern = 8'($urandom); src_cpu = 1'($urandom);
    mode = 2'($urandom); fg_color = 4'($urandom); bg_color = 4'($urandom);
    fg_latch = $urandom; rd_latch = $urandom; sr_value = 4'($urandom);
    sr_enable = 4'($urandom); bit_mask = 8'($urandom);
    mw_enable = 1'($urandom); mw_use_cpu = 1'($urandom); mw_mask = 8'($urandom);
  endtask

  task automatic do_write();
    string dtag;
    exp_m = f_mask();
    exp_d = f_data(exp_m);
    case (mode)
      2'd0: dtag = "R2";
      2'd1: dtag = src_cpu ? "R3" : "R1";
      2'd2: dtag = "R4";
      default: dtag = "R5";
    endcase
    wr_stb = 1;
    @(negedge clk);
    wr_stb = 0;
    chk("R8 valid", 32'(out_valid), 32'd1);
    chk(dtag, plane_data, exp_d);
    chk("R6 mask", 32'(wr_mask), 32'(exp_m));
    chk("R7 keep", (plane_data ^ rd_latch) & ~{4{wr_mask}}, 32'd0);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R10 data", plane_data, 32'd0);
    chk("R10 mask", 32'(wr_mask), 32'd0);
    chk("R10 valid", 32'(out_valid), 32'd0);
    rst_n = 1;
    @(negedge clk);

    // directed: mode 1 with pattern source and cpu-driven mask
    randomize_inputs();
    mode = 2'd1; src_cpu = 0; pattern = 8'hA5; cpu_data = 8'h3C;
    fg_color = 4'b1010; bg_color = 4'b0110; bit_mask = 8'hFF;
    mw_enable = 1; mw_use_cpu = 1; mw_mask = 8'h0F;
    do_write();
    // same with cpu source
    src_cpu = 1;
    do_write();
    // mode 0 mixing set/reset and cpu planes, all bits enabled
    mode = 2'd0; sr_enable = 4'b0101; sr_value = 4'b0001; cpu_data = 8'h96;
    mw_enable = 0; bit_mask = 8'hFF;
    do_write();
    // fully masked: data must equal read latch
    mode = 2'd2; bit_mask = 8'h00;
    do_write();
    // masked-write register path
    mode = 2'd3; bit_mask = 8'hF0; mw_enable = 1; mw_use_cpu = 0; mw_mask = 8'h3C;
    do_write();

    for (int i = 0; i < 300; i++) begin
      randomize_inputs();
      do_write();
      if (($urandom % 3) == 0) begin
        held_d = plane_data; held_m = wr_mask;
        randomize_inputs();
        @(negedge clk);
        chk("R8 idle", 32'(out_valid), 32'd0);
        chk("R9 hold data", plane_data, held_d);
        chk("R9 hold mask", 32'(wr_mask), 32'(held_m));
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule